// File: doc/BRIEF.md
# Serial Channel Status Latch with Break and Abort Detection

This block holds the condition-change logic for one channel of a serial receiver/transmitter. It watches finished receive characters and their framing-error flags, and also the raw receive bit stream. From these it reports a line break in asynchronous mode or an abort flag sequence in bit-oriented (SDLC) mode. Both conditions share one status bit. The block also keeps a sticky transmit underrun / end-of-message latch and shows the inverted clear-to-send input.

Any change of a monitored condition raises an interrupt request, provided interrupts are enabled. While the request is pending, the status byte seen by the processor stays frozen. A reset-interrupt command clears the request and shows the current conditions again.

The break/abort detector disarms itself after each start or end it reports, so the start and the end of a break each produce their own interrupt. The same command that clears the request re-arms the detector. Characters that arrive while the detector is disarmed, such as a leftover null after a break, do not change the status.

Top module: `serstat_latch`

## Requirements
- R1: While reset is held and right after it, `status` is 0x40 and `irq` is 0. Bits 4:0 of `status` are always 0.
- R2: In asynchronous mode (`rx_mode` 00), a character strobe with all-zero data and `chr_ferr` high sets `status[7]` if the detector is armed. The detector is armed after reset.
- R3: In asynchronous mode, while `status[7]` is set and the detector is armed, the first character that is not (all-zero with framing error) clears `status[7]`. Characters that arrive while the detector is disarmed are ignored, including a stray null with framing error.
- R4: Each reported start or end of a break or abort disarms the detector. `cmd_clr_ext` re-arms it. If a detection and the command fall in the same cycle, the detector stays disarmed.
- R5: In SDLC mode (`rx_mode` 10), `ONES_LIM` (default 7) consecutive 1 bits on `bit_stb` set `status[7]` while the detector is armed. A 0 bit restarts the count. After an abort, the first 0 bit received while armed clears `status[7]`.
- R6: In synchronous mode (`rx_mode` 01 or 11), `status[7]` stays 0 and received characters and bits have no effect on it.
- R7: A `tx_urun` pulse sets `status[6]` and counts as a condition change. `cmd_clr_urun` clears `status[6]`. If both occur in the same cycle, the bit ends up set.
- R8: `status[5]` shows the inverse of `cts`. Every change of `cts` counts as a condition change.
- R9: A condition change with `ext_ie` high sets `irq`. `irq` stays high until `cmd_clr_ext`. While `irq` is high, `status` does not change. The command loads the current conditions into `status`. A change in the same cycle as the command keeps `irq` high.
- R10: With `ext_ie` low, `irq` never rises and `status` follows the conditions with one cycle of delay.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rx_mode | input | 2 | 00 async, 10 SDLC, 01/11 synchronous |
| ext_ie | input | 1 | Condition-change interrupt enable |
| chr_stb | input | 1 | Received character valid |
| chr_data | input | DW | Received character |
| chr_ferr | input | 1 | Framing error of the received character |
| bit_stb | input | 1 | Raw receive bit valid |
| bit_val | input | 1 | Raw receive bit value |
| tx_urun | input | 1 | Transmit underrun pulse |
| cts | input | 1 | Clear-to-send pin level |
| cmd_clr_ext | input | 1 | Reset-interrupt command strobe; re-arms the detector |
| cmd_clr_urun | input | 1 | Reset underrun/EOM latch command strobe |
| status | output | 8 | [7] break/abort, [6] underrun/EOM, [5] inverted CTS |
| irq | output | 1 | Interrupt request |

## Verification
Every result of this block is registered once. A strobe, pin change or command sampled at one rising edge shows on `status` and `irq` right after that edge, so each result is due one cycle after its stimulus. The bench changes inputs on the falling edge, lets exactly one rising edge pass, and compares both outputs on the next falling edge. Same-cycle collisions (detection with command, underrun set with clear, change with release) are placed in single vectors so their one-cycle outcome is checked directly.

// File: rtl/serstat_latch.sv
module serstat_latch #(
  parameter int DW       = 8,
  parameter int ONES_LIM = 7
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [1:0]    rx_mode,
  input  logic          ext_ie,
  input  logic          chr_stb,
  input  logic [DW-1:0] chr_data,
  input  logic          chr_ferr,
  input  logic          bit_stb,
  input  logic          bit_val,
  input  logic          tx_urun,
  input  logic          cts,
  input  logic          cmd_clr_ext,
  input  logic          cmd_clr_urun,
  output logic [7:0]    status,
  output logic          irq
);
  localparam int CW = $clog2(ONES_LIM + 1);
  localparam logic [CW-1:0] LIM = CW'(ONES_LIM);

  logic          brk_q, urun_q, cts_q, armed_q, pend_q;
  logic [CW-1:0] ones_q;
  logic [2:0]    snap_q;

  wire is_async = (rx_mode == 2'b00);
  wire is_sdlc  = (rx_mode == 2'b10);
  wire null_err = chr_stb && (chr_data == '0) && chr_ferr;

  wire brk_on  = armed_q && !brk_q &&
                 ((is_async && null_err) ||
                  (is_sdlc && bit_stb && bit_val && (ones_q >= LIM - CW'(1))));
  wire brk_off = armed_q && brk_q &&
                 ((is_async && chr_stb && !null_err) ||
                  (is_sdlc && bit_stb && !bit_val));

  wire brk_d  = (is_async || is_sdlc) && (brk_on || (brk_q && !brk_off));
  wire urun_d = tx_urun || (urun_q && !cmd_clr_urun);
  wire cts_d  = !cts;
  wire evt    = brk_on || brk_off || tx_urun || (cts_d != cts_q);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      brk_q   <= 1'b0;
      urun_q  <= 1'b1;
      cts_q   <= 1'b0;
      armed_q <= 1'b1;
      pend_q  <= 1'b0;
      ones_q  <= '0;
      snap_q  <= 3'b010;
    end else begin
      brk_q  <= brk_d;
      urun_q <= urun_d;
      cts_q  <= cts_d;

      if (!is_sdlc)
        ones_q <= '0;
      else if (bit_stb)
        ones_q <= !bit_val ? '0 : (ones_q == LIM) ? ones_q : ones_q + CW'(1);

      if (brk_on || brk_off)
        armed_q <= 1'b0;
      else if (cmd_clr_ext)
        armed_q <= 1'b1;

      pend_q <= (pend_q && !cmd_clr_ext) || (evt && ext_ie);

      if (!pend_q || cmd_clr_ext)
        snap_q <= {brk_d, urun_d, cts_d};
    end
  end

  assign status = {snap_q, 5'b00000};
  assign irq    = pend_q;
endmodule

module serstat_latch_chk (
  input logic       clk,
  input logic       rst_n,
  input logic [1:0] rx_mode,
  input logic       ext_ie,
  input logic       tx_urun,
  input logic       cts,
  input logic       cmd_clr_ext,
  input logic [7:0] status,
  input logic       irq
);
  // R1
  low_bits_chk: assert property (@(posedge clk) disable iff (!rst_n)
    status[4:0] == 5'b0 |=> status[4:0] == 5'b0);

  // R9
  irq_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (irq && !cmd_clr_ext) |=> irq);

  // R9
  stat_frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (irq && !cmd_clr_ext) |=> $stable(status));

  // R6
  sync_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_mode[0] && (!irq || cmd_clr_ext)) |=> !status[7]);

  // R7
  urun_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_urun && (!irq || cmd_clr_ext)) |=> status[6]);

  // R8
  cts_track_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!irq && !ext_ie) |=> status[5] == !$past(cts));

  // R10
  no_ie_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!ext_ie && (!irq || cmd_clr_ext)) |=> !irq);
endmodule

bind serstat_latch serstat_latch_chk u_chk (
  .clk(clk), .rst_n(rst_n), .rx_mode(rx_mode), .ext_ie(ext_ie),
  .tx_urun(tx_urun), .cts(cts), .cmd_clr_ext(cmd_clr_ext),
  .status(status), .irq(irq)
);

// File: tb/sim_serstat_latch.sv
module sim_serstat_latch;
  logic       clk = 1'b0;
  logic       rst_n;
  logic [1:0] rx_mode;
  logic       ext_ie, chr_stb, chr_ferr, bit_stb, bit_val;
  logic       tx_urun, cts, cmd_clr_ext, cmd_clr_urun;
  logic [7:0] chr_data;
  logic [7:0] status;
  logic       irq;

  int runs = 0;
  int fails = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  serstat_latch u0 (
    .clk(clk), .rst_n(rst_n), .rx_mode(rx_mode), .ext_ie(ext_ie),
    .chr_stb(chr_stb), .chr_data(chr_data), .chr_ferr(chr_ferr),
    .bit_stb(bit_stb), .bit_val(bit_val), .tx_urun(tx_urun), .cts(cts),
    .cmd_clr_ext(cmd_clr_ext), .cmd_clr_urun(cmd_clr_urun),
    .status(status), .irq(irq)
  );

  // {mode[27:26], ie, cs, data[23:16], fe, bs, bv, ur, cts, ce, cu, exp_stat[8:1], exp_irq}
  localparam int NV = 23;
  localparam logic [27:0] VEC [NV] = '{
    {2'd0,1'b1,1'b0,8'h00,1'b0,1'b0,1'b0,1'b0,1'b1,1'b0,1'b1,8'h00,1'b0},
    {2'd0,1'b1,1'b1,8'h41,1'b0,1'b0,1'b0,1'b0,1'b1,1'b0,1'b0,8'h00,1'b0},
    {2'd0,1'b1,1'b1,8'h00,1'b0,1'b0,1'b0,1'b0,1'b1,1'b0,1'b0,8'h00,1'b0},
    {2'd0,1'b1,1'b1,8'h55,1'b1,1'b0,1'b0,1'b0,1'b1,1'b0,1'b0,8'h00,1'b0},
    {2'd0,1'b1,1'b1,8'h00,1'b1,1'b0,1'b0,1'b0,1'b1,1'b0,1'b0,8'h80,1'b1},
    {2'd0,1'b1,1'b1,8'h00,1'b1,1'b0,1'b0,1'b0,1'b1,1'b0,1'b0,8'h80,1'b1},
    {2'd0,1'b1,1'b0,8'h00,1'b0,1'b0,1'b0,1'b0,1'b1,1'b1,1'b0,8'h80,1'b0},
    {2'd0,1'b1,1'b1,8'h00,1'b1,1'b0,1'b0,1'b0,1'b1,1'b0,1'b0,8'h80,1'b0},
    {2'd0,1'b1,1'b1,8'h12,1'b0,1'b0,1'b0,1'b0,1'b1,1'b0,1'b0,8'h00,1'b1},
    {2'd0,1'b1,1'b1,8'h00,1'b1,1'b0,1'b0,1'b0,1'b1,1'b0,1'b0,8'h00,1'b1},
    {2'd0,1'b1,1'b0,8'h00,1'b0,1'b0,1'b0,1'b0,1'b1,1'b1,1'b0,8'h00,1'b0},
    {2'd0,1'b1,1'b0,8'h00,1'b0,1'b0,1'b0,1'b1,1'b1,1'b0,1'b0,8'h40,1'b1},
    {2'd0,1'b1,1'b0,8'h00,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,8'h40,1'b1},
    {2'd0,1'b1,1'b0,8'h00,1'b0,1'b0,1'b0,1'b0,1'b0,1'b1,1'b0,8'h60,1'b0},
    {2'd0,1'b1,1'b0,8'h00,1'b0,1'b0,1'b0,1'b0,1'b1,1'b0,1'b0,8'h40,1'b1},
    {2'd0,1'b1,1'b0,8'h00,1'b0,1'b0,1'b0,1'b0,1'b1,1'b1,1'b1,8'h00,1'b0},
    {2'd0,1'b0,1'b0,8'h00,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,8'h20,1'b0},
    {2'd0,1'b0,1'b0,8'h00,1'b0,1'b0,1'b0,1'b0,1'b1,1'b0,1'b0,8'h00,1'b0},
    {2'd0,1'b1,1'b1,8'h00,1'b1,1'b0,1'b0,1'b0,1'b1,1'b0,1'b0,8'h80,1'b1},
    {2'd0,1'b1,1'b1,8'h00,1'b1,1'b0,1'b0,1'b0,1'b1,1'b1,1'b0,8'h80,1'b0},
    {2'd0,1'b1,1'b1,8'h33,1'b0,1'b0,1'b0,1'b0,1'b1,1'b1,1'b0,8'h00,1'b1},
    {2'd0,1'b1,1'b0,8'h00,1'b0,1'b0,1'b0,1'b1,1'b1,1'b0,1'b1,8'h00,1'b1},
    {2'd0,1'b1,1'b0,8'h00,1'b0,1'b0,1'b0,1'b0,1'b1,1'b1,1'b0,8'h40,1'b0}
  };
  localparam string TAG [NV] = '{
    "R7", "R2", "R2", "R2", "R2", "R4", "R9", "R3", "R3", "R3", "R4", "R7",
    "R9", "R9", "R8", "R9", "R10", "R10", "R4", "R9", "R4", "R7", "R9"
  };

  task automatic idle();
    chr_stb = 1'b0; chr_data = 8'h00; chr_ferr = 1'b0;
    bit_stb = 1'b0; bit_val = 1'b0; tx_urun = 1'b0;
    cmd_clr_ext = 1'b0; cmd_clr_urun = 1'b0;
  endtask

  task automatic check(input string tag, input logic [7:0] es, input logic ei);
    runs++;
    if (status !== es || irq !== ei) begin
      fails++;
      $display("FAIL %s: status=%h irq=%b expected status=%h irq=%b", tag, status, irq, es, ei);
    end
  endtask

  task automatic cycle();
    @(posedge clk);
    @(negedge clk);
    idle();
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0; rx_mode = 2'd0; ext_ie = 1'b1; cts = 1'b1;
    idle();
    @(posedge clk);
    @(negedge clk);
    check("R1", 8'h40, 1'b0);
    rst_n = 1'b1;
  endtask

  task automatic send_bit(input logic b);
    bit_stb = 1'b1; bit_val = b;
    cycle();
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: actual=running expected=finished");
      $display("[TB] %0d tests run, %0d failed", runs, fails);
      $finish;
    end
  end

  initial begin
    do_reset();
    cycle();
    check("R1", 8'h40, 1'b0);

    for (int i = 0; i < NV; i++) begin
      rx_mode      = VEC[i][27:26];
      ext_ie       = VEC[i][25];
      chr_stb      = VEC[i][24];
      chr_data     = VEC[i][23:16];
      chr_ferr     = VEC[i][15];
      bit_stb      = VEC[i][14];
      bit_val      = VEC[i][13];
      tx_urun      = VEC[i][12];
      cts          = VEC[i][11];
      cmd_clr_ext  = VEC[i][10];
      cmd_clr_urun = VEC[i][9];
      cycle();
      check(TAG[i], VEC[i][8:1], VEC[i][0]);
    end

    // R5: abort in bit-oriented mode
    do_reset();
    rx_mode = 2'd2;
    cmd_clr_urun = 1'b1;
    cycle();
    check("R7", 8'h00, 1'b0);
    for (int k = 0; k < 6; k++) send_bit(1'b1);
    check("R5", 8'h00, 1'b0);
    send_bit(1'b1);
    check("R5", 8'h80, 1'b1);
    cmd_clr_ext = 1'b1;
    cycle();
    check("R5", 8'h80, 1'b0);
    send_bit(1'b1);
    check("R5", 8'h80, 1'b0);
    send_bit(1'b0);
    check("R5", 8'h00, 1'b1);
    cmd_clr_ext = 1'b1;
    cycle();
    check("R4", 8'h00, 1'b0);
    for (int k = 0; k < 5; k++) send_bit(1'b1);
    send_bit(1'b0);
    send_bit(1'b1);
    send_bit(1'b1);
    check("R5", 8'h00, 1'b0);
    for (int k = 0; k < 4; k++) send_bit(1'b1);
    check("R5", 8'h00, 1'b0);
    send_bit(1'b1);
    check("R5", 8'h80, 1'b1);

    // R6: synchronous mode ignores break and abort inputs
    do_reset();
    rx_mode = 2'd1;
    cmd_clr_urun = 1'b1;
    cycle();
    chr_stb = 1'b1; chr_data = 8'h00; chr_ferr = 1'b1;
    cycle();
    check("R6", 8'h00, 1'b0);
    for (int k = 0; k < 8; k++) send_bit(1'b1);
    check("R6", 8'h00, 1'b0);
    rx_mode = 2'd3;
    chr_stb = 1'b1; chr_data = 8'h00; chr_ferr = 1'b1;
    cycle();
    check("R6", 8'h00, 1'b0);

    // R3: async mode ignores the raw bit stream
    rx_mode = 2'd0;
    for (int k = 0; k < 8; k++) send_bit(1'b1);
    check("R3", 8'h00, 1'b0);

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", runs, fails);
    $finish;
  end
endmodule